// File: doc/BRIEF.md
# Loadable XNOR-Feedback Shift-Register Interval Timer

This block times one interval using a 35-bit shift register with XNOR feedback in place of a binary counter. The goal is a timer that takes very few lookup tables and has a next-state path of one gate level, so a design can hold many copies. The controlling logic presets the register while it holds the timer in reset. It then raises the run input, and the register moves one state per clock toward the all-zero state. That state marks the end of the interval. On reaching it the register stops and a done flag rises. The flag stays up until the timer is loaded again. Working out which preset gives a wanted interval is left to software.

A single 35-input compare for zero would sit in the same cycle as the step decision. To avoid that, the zero test is split across two register stages. Stage one stores 6-bit slice matches of the current state. The stored slices are checked against three fixed patterns: zero, the state one step before zero, and the state two steps before zero. Stage two combines each set of matches with a note of whether the register stepped in the previous cycle. From this it knows whether the present state is zero or one step from zero. It uses that to stop the register on zero and to raise done in the same cycle the count reads zero. The detector needs one settle cycle after reset is released.

Top module: `lfsr_oneshot_timer`

## Requirements
- R1: Each step shifts the state one place toward the MSB, and the new bit 0 is the inverse of (bit 34 XOR bit 32), with bits numbered from 0. At most one step happens per clock.
- R2: While `rst` is high and `ld` is high, the next edge loads `preset` into the state. `run` has no effect while `rst` is high.
- R3: While `rst` is high and `ld` is low, the state keeps its value.
- R4: `done_o` is low during reset and in the first cycle after `rst` falls. The first step can happen at the second rising edge that samples `rst` low.
- R5: When `run` is low outside reset, the state keeps its value.
- R6: Once the state is all-zero it stays all-zero, even with `run` high, until the next load.
- R7: From the second cycle after reset release, `done_o` is high exactly when `count_o` is all-zero. This holds in the same cycle the count reaches zero, for presets 0, 1, 2 and 3 steps from zero.
- R8: `done_o` stays high while the state is zero, with `run` high or low. A load in reset clears it.
- R9: A preset that lies D steps before zero reaches zero after D clock edges on which the timer is free to step and `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the preset may be loaded only during reset |
| ld | input | 1 | Load strobe, acted on only while `rst` is high |
| preset | input | 35 | Start state for the interval |
| run | input | 1 | Step enable |
| count_o | output | 35 | Current register state |
| done_o | output | 1 | Interval complete (state is all-zero) |

## Verification
A wrong slice flag or a bad stepped-last-cycle bit shows at the ports within one or two cycles. It appears either as `done_o` rising on a non-zero count or as the count moving past zero into the rest of the sequence. A feedback fault shows one step after the fault as a `count_o` value that differs from the independent next-state model. Presets placed 0 to 3 steps from zero, and pauses of `run` just before zero, drive the lookahead through every case of its compensation logic.

// File: rtl/lfsr_timer_pkg.sv
package lfsr_timer_pkg;
  localparam int unsigned DEF_WIDTH  = 35;  // register length, high tap is the MSB
  localparam int unsigned DEF_TAP_LO = 33;  // second feedback tap (1-based)
  localparam int unsigned DEF_SLICE  = 6;   // bits per stage-one compare slice
endpackage

// File: rtl/lfsr_shift_core.sv
module lfsr_shift_core #(
  parameter int unsigned W      = 35,
  parameter int unsigned TAP_LO = 33
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] preset_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  // XNOR feedback: all-zero is a legal state, all-ones is the lockup value
  assign fb = ~(state_q[W-1] ^ state_q[TAP_LO-1]);

  always_ff @(posedge clk) begin
    if (rst_i) begin
      if (load_i) state_q <= preset_i;
    end else if (step_i) begin
      state_q <= {state_q[W-2:0], fb};
    end
  end

  assign state_o = state_q;

  a_r2_load_in_reset: assert property (@(posedge clk)
    rst_i && load_i |=> state_o == $past(preset_i));

  a_r3_hold_in_reset: assert property (@(posedge clk)
    rst_i && !load_i |=> $stable(state_o));

  a_r1_shift_up: assert property (@(posedge clk) disable iff (rst_i)
    step_i |=> state_o[W-1:1] == $past(state_o[W-2:0]));
endmodule

// File: rtl/zero_lookahead.sv
module zero_lookahead #(
  parameter int unsigned W      = 35,
  parameter int unsigned TAP_LO = 33,
  parameter int unsigned SLICE  = 6
) (
  input  logic         clk,
  input  logic         rst_i,
  input  logic         run_i,
  input  logic [W-1:0] state_i,
  output logic         step_o,
  output logic         done_o
);
  localparam int unsigned NS = (W + SLICE - 1) / SLICE;
  localparam int unsigned NT = 3;  // targets: 0, 1 and 2 steps before zero

  // Walk the sequence backwards from zero n times
  function automatic logic [W-1:0] rewind(input int unsigned n);
    logic [W-1:0] v;
    v = '0;
    for (int unsigned j = 0; j < n; j++) v = {~v[0] ^ v[TAP_LO], v[W-1:1]};
    return v;
  endfunction

  logic [NT*NS-1:0] slice_c;
  logic [NT*NS-1:0] slice_q;
  logic             stepped_q;
  logic             armed_q;
  logic             done_q;
  logic             was0, was1, was2;
  logic             at_zero, at_one;

  for (genvar k = 0; k < NT; k++) begin : g_tgt
    localparam logic [W-1:0] TGT = rewind(k);
    for (genvar i = 0; i < NS; i++) begin : g_slice
      localparam int unsigned LO  = i * SLICE;
      localparam int unsigned TOP = (LO + SLICE > W) ? W : LO + SLICE;
      assign slice_c[k*NS+i] = (state_i[TOP-1:LO] == TGT[TOP-1:LO]);
    end
  end

  // stage one: registered slice matches of the state seen last cycle
  always_ff @(posedge clk) begin
    slice_q   <= slice_c;
    stepped_q <= step_o;
    armed_q   <= ~rst_i;
  end

  // stage two: combine slices, then correct for a step taken meanwhile
  assign was0 = &slice_q[0*NS +: NS];
  assign was1 = &slice_q[1*NS +: NS];
  assign was2 = &slice_q[2*NS +: NS];

  assign at_zero = stepped_q ? was1 : was0;
  assign at_one  = stepped_q ? was2 : was1;

  assign step_o = run_i & armed_q & ~rst_i & ~at_zero;

  always_ff @(posedge clk) begin
    if (rst_i) done_q <= 1'b0;
    else       done_q <= armed_q & (at_zero | (at_one & step_o));
  end

  assign done_o = done_q;

  a_r4_no_step_unarmed: assert property (@(posedge clk) disable iff (rst_i)
    !armed_q |-> !step_o);
endmodule

// File: rtl/lfsr_oneshot_timer.sv
module lfsr_oneshot_timer
  import lfsr_timer_pkg::*;
#(
  parameter int unsigned W      = DEF_WIDTH,
  parameter int unsigned TAP_LO = DEF_TAP_LO,
  parameter int unsigned SLICE  = DEF_SLICE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] preset,
  input  logic         run,
  output logic [W-1:0] count_o,
  output logic         done_o
);
  logic         step;
  logic [W-1:0] state;

  lfsr_shift_core #(.W(W), .TAP_LO(TAP_LO)) u_core (
    .clk      (clk),
    .rst_i    (rst),
    .load_i   (ld),
    .preset_i (preset),
    .step_i   (step),
    .state_o  (state)
  );

  zero_lookahead #(.W(W), .TAP_LO(TAP_LO), .SLICE(SLICE)) u_detect (
    .clk     (clk),
    .rst_i   (rst),
    .run_i   (run),
    .state_i (state),
    .step_o  (step),
    .done_o  (done_o)
  );

  assign count_o = state;

  a_r4_done_low_reset: assert property (@(posedge clk)
    rst |=> !done_o);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_o));

  a_r6_zero_freeze: assert property (@(posedge clk) disable iff (rst)
    (count_o == '0) |=> (count_o == '0));

  a_r7_done_means_zero: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (count_o == '0));

  a_r8_done_holds: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
endmodule

// File: tb/tb_lfsr_oneshot_timer.sv
`timescale 1ns/100ps
module tb_lfsr_oneshot_timer;
  localparam int W = 35;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld = 1'b0;
  logic [W-1:0] preset = '0;
  logic         run = 1'b0;
  logic [W-1:0] count_o;
  logic         done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  lfsr_oneshot_timer dut (
    .clk(clk), .rst(rst), .ld(ld), .preset(preset), .run(run),
    .count_o(count_o), .done_o(done_o)
  );

  typedef struct {
    logic [W-1:0] cnt;
    bit           cnt_known;
    bit           dn;
    string        tag;
  } exp_t;

  exp_t sb[$];

  // bench model state
  logic [W-1:0] m_state = '0;
  bit           m_known = 0;
  int           m_free  = 0;  // non-reset edges seen since release, saturating

  function automatic logic [W-1:0] fwd(input logic [W-1:0] s);
    return {s[W-2:0], ~(s[34] ^ s[32])};
  endfunction

  function automatic logic [W-1:0] before_zero(input int d);
    logic [W-1:0] t;
    t = '0;
    for (int j = 0; j < d; j++) t = {~t[0] ^ t[33], t[W-1:1]};
    return t;
  endfunction

  // driver: apply inputs for one cycle, predict the outputs after the edge
  task automatic cyc(input bit r, input bit l, input logic [W-1:0] p,
                     input bit en, input string tag);
    exp_t e;
    rst = r; ld = l; preset = p; run = en;
    @(posedge clk);
    if (r) begin
      m_free = 0;
      if (l) begin m_state = p; m_known = 1; end
    end else begin
      if (m_free < 2) m_free++;
      if (m_free >= 2 && en && m_state != '0) m_state = fwd(m_state);
    end
    e.cnt = m_state;
    e.cnt_known = m_known;
    e.dn = !r && (m_free >= 2) && (m_state == '0);
    e.tag = tag;
    sb.push_back(e);
    #1;
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      if (e.cnt_known) begin
        checks++;
        if (count_o !== e.cnt) begin
          errors++;
          $display("FAIL %s count got %h exp %h", e.tag, count_o, e.cnt);
        end
      end
      checks++;
      if (done_o !== e.dn) begin
        errors++;
        $display("FAIL %s done got %0b exp %0b", e.tag, done_o, e.dn);
      end
    end
  end

  task automatic load_preset(input logic [W-1:0] p);
    cyc(1, 1, p, 0, "R2 load");
    cyc(1, 0, '0, 1, "R3 hold in reset");
  endtask

  initial begin
    // R4: reset state, done low
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 0, "R4 reset");

    // R2: load while run high in reset, no stepping
    cyc(1, 1, before_zero(20), 1, "R2 load priority");
    cyc(1, 0, 35'h7_0F0F_0F0F, 1, "R2 R3 hold in reset");
    cyc(1, 0, '0, 1, "R3 hold in reset");

    // R9 R7 R6: 20 steps to zero, then frozen with run high
    for (int i = 0; i < 30; i++) cyc(0, 0, '0, 1, "R9 R7 R6 count down");
    // R8 R5: done held with run low
    for (int i = 0; i < 3; i++) cyc(0, 0, '0, 0, "R8 R5 done hold");

    // R8: load clears done; R1 R5: generic sequence with pauses
    cyc(1, 1, 35'h0_1234_5678, 0, "R8 clear on load");
    cyc(1, 0, '0, 0, "R3 hold in reset");
    for (int i = 0; i < 60; i++) cyc(0, 0, '0, (i % 3) != 0, "R1 R5 sequence");

    // R7: corner distances through the lookahead
    for (int d = 0; d < 4; d++) begin
      load_preset(before_zero(d));
      for (int i = 0; i < d + 6; i++) cyc(0, 0, '0, 1, "R7 R9 short distance");
    end

    // R5 R7: pauses right before zero
    load_preset(before_zero(5));
    for (int i = 0; i < 16; i++) cyc(0, 0, '0, i[0], "R5 R7 pause near zero");

    // R3: reset without load keeps a mid-count value; R4 settle cycle
    load_preset(35'h2_AAAA_5555);
    for (int i = 0; i < 7; i++) cyc(0, 0, '0, 1, "R1 run");
    for (int i = 0; i < 3; i++) cyc(1, 0, '0, 1, "R3 R4 reset no load");
    for (int i = 0; i < 4; i++) cyc(0, 0, '0, 1, "R4 release settle");

    cyc(0, 0, '0, 0, "R5 idle");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule